// File: doc/BRIEF.md
# Condition-Register Mask-Test Unit

This execution unit carries out four scalar operations that move condition information between the 32-bit condition register and an integer result. Each operation tests a 4-bit source group against a 4-bit pattern, and a 4-bit mask picks which of the four comparisons take part. The source group is one condition field, or the least significant bit of the integer operand copied into all four positions. The surviving comparison terms are then handled in one of two ways. They can be folded into a single bit by AND or by OR. They can also be written back whole as a 4-bit condition field.

The unit takes a decoded instruction word, the current condition register, one integer operand and the current summary-overflow flag. One cycle later it returns an integer write (data plus enable) and the complete next condition register, with one write-enable per field. Two selector bits in the instruction choose the flow:

- condition field to integer bit
- integer bit to condition field
- condition field to condition field
- condition field to one chosen condition bit

Top module: `crmask_unit`

## Requirements
- R1: Writes occur only when `in_valid` is high, instruction bits 31:26 equal 19, bits 10:6 equal parameter `XO_HI` (default 5'b10110) and bit 5 is 0. In every other cycle `int_we` is 0, `cr_we` is 0 and `cr_out` equals the `cr_in` sampled one cycle earlier.
- R2: Comparison term k (k = 0..3) is `mask[k] & (mode[k] == src[k])`. `mask[k]` is instruction bit 19-k. `mode[k]` is bit 4-k. The source field index is bits 15:13. Condition field f holds its bit k at `cr[31-4f-k]`, with k = 0 lt, 1 gt, 2 eq, 3 so. Field 0 is therefore the top nibble.
- R3: With bit 20 = 0 and bit 12 = 0 (field to integer), the four terms are folded by OR when bit 11 is 1 and by AND when it is 0. `int_wdata` is that bit in position 0 with zeros above, and `int_we` is 1.
- R4: In the field-to-integer flow with bit 0 set, field 1 is rewritten from the integer result: lt when it is negative (signed), gt when it is positive, eq when it is zero, and so from `so_in`. `cr_we[1]` is 1.
- R5: With bit 20 = 1 and bit 12 = 0 (integer to field), all four source bits equal `int_op[0]`. The four terms are written as a nibble into the field named by bits 15:13.
- R6: In the integer-to-field flow, when bits 25:21 are zero, the operand is taken as zero. Mask 1111 with pattern ~v then writes v, pattern 0000 sets the masked bits, and pattern 1111 clears them.
- R7: With bit 20 = 0 and bit 12 = 1 (field to field), the four terms are written as a nibble into the field named by bits 25:23.
- R8: With bit 20 = 1 and bit 12 = 1 (field to bit), the folded bit (see R3) is written to bit index bits 25:24 of the field named by bits 23:21. The other three bits of that field keep their values.
- R9: Results appear on the outputs one clock after the inputs. Any field whose `cr_we` bit is 0 keeps its value in `cr_out`, and `cr_we` bit f marks field f.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| insn | input | 32 | Instruction word |
| cr_in | input | 32 | Current condition register |
| int_op | input | XLEN | Integer source operand |
| so_in | input | 1 | Summary-overflow flag for the Rc update |
| int_we | output | 1 | Integer result write enable |
| int_wdata | output | XLEN | Integer result |
| cr_we | output | 8 | Per-field write enable, bit f = field f |
| cr_out | output | 32 | Next condition register |

## Verification
Several properties are checked on every cycle:

- an unselected or idle cycle never raises an enable;
- at most one field enable is high at a time;
- an integer write has zeros above bit 0;
- any field without an enable matches the condition register of the cycle before;
- the Rc-updated field agrees with the integer result it came from.

Other behaviour only the bench's scenarios can show: whether the right terms were formed, the AND/OR choice, the zero-operand constant patterns, and the exact field and bit a write lands on. The bench computes these for directed patterns and for random instructions.

// File: rtl/crmask_unit.sv
module crmask_unit #(
  parameter int          XLEN  = 64,
  parameter logic [4:0]  XO_HI = 5'b10110
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic [31:0]     cr_in,
  input  logic [XLEN-1:0] int_op,
  input  logic            so_in,
  output logic            int_we,
  output logic [XLEN-1:0] int_wdata,
  output logic [7:0]      cr_we,
  output logic [31:0]     cr_out
);

  localparam logic [5:0] PRIMARY = 6'd19;

  logic       hit, to_int, int_src, sel_hi, sel_lo, fold_or, rc;
  logic [0:3] mask, mode, src, terms;
  logic [2:0] bb, bt, bf;
  logic [1:0] bsel;
  logic [4:0] t5;
  logic       lsb, folded;

  assign hit     = in_valid && insn[31:26] == PRIMARY && insn[10:6] == XO_HI && !insn[5];
  assign sel_hi  = insn[20];
  assign sel_lo  = insn[12];
  assign mask    = insn[19:16];
  assign mode    = insn[4:1];
  assign bb      = insn[15:13];
  assign t5      = insn[25:21];
  assign bt      = insn[25:23];
  assign bf      = insn[23:21];
  assign bsel    = insn[25:24];
  assign fold_or = insn[11];
  assign rc      = insn[0];
  assign to_int  = !sel_hi && !sel_lo;
  assign int_src = sel_hi && !sel_lo;
  assign lsb     = (t5 == 5'd0) ? 1'b0 : int_op[0];

  function automatic logic [0:3] field_of(logic [31:0] cr, logic [2:0] f);
    return cr[31-4*f -: 4];
  endfunction

  assign src    = int_src ? {4{lsb}} : field_of(cr_in, bb);
  assign terms  = mask & ~(mode ^ src);
  assign folded = fold_or ? |terms : &terms;

  logic [XLEN-1:0] res_nx;
  logic [31:0]     cr_nx;
  logic [7:0]      we_nx;
  logic            iwe_nx;

  always_comb begin
    cr_nx  = cr_in;
    we_nx  = '0;
    iwe_nx = 1'b0;
    res_nx = '0;
    if (hit) begin
      if (to_int) begin
        iwe_nx    = 1'b1;
        res_nx[0] = folded;
        if (rc) begin
          we_nx[1]     = 1'b1;
          cr_nx[27:24] = {res_nx[XLEN-1],
                          !res_nx[XLEN-1] && |res_nx,
                          ~|res_nx,
                          so_in};
        end
      end else if (int_src) begin
        we_nx[bb]            = 1'b1;
        cr_nx[31-4*bb -: 4]  = terms;
      end else if (!sel_hi) begin
        we_nx[bt]            = 1'b1;
        cr_nx[31-4*bt -: 4]  = terms;
      end else begin
        we_nx[bf]                 = 1'b1;
        cr_nx[31-4*bf-bsel]       = folded;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_we    <= 1'b0;
      int_wdata <= '0;
      cr_we     <= '0;
      cr_out    <= '0;
    end else begin
      int_we    <= iwe_nx;
      int_wdata <= res_nx;
      cr_we     <= we_nx;
      cr_out    <= cr_nx;
    end
  end

endmodule

// File: rtl/crmask_unit_chk.sv
module crmask_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     cr_in,
  input logic            int_we,
  input logic [XLEN-1:0] int_wdata,
  input logic [7:0]      cr_we,
  input logic [31:0]     cr_out
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(in_valid) |-> !int_we && cr_we == 8'd0);

  // R9
  one_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cr_we));

  // R3
  int_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_we |-> int_wdata[XLEN-1:1] == '0);

  // R4
  int_only_cr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_we |-> (cr_we & 8'hFD) == 8'd0);

  // R4
  rc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_we && cr_we[1] |-> !cr_out[27] && cr_out[26] == int_wdata[0] && cr_out[25] == !int_wdata[0]);

  for (genvar f = 0; f < 8; f++) begin : g_keep
    // R9
    field_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && !cr_we[f] |-> cr_out[31-4*f -: 4] == $past(cr_in[31-4*f -: 4]));
  end

endmodule

bind crmask_unit crmask_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cr_in(cr_in),
  .int_we(int_we), .int_wdata(int_wdata), .cr_we(cr_we), .cr_out(cr_out)
);

// File: tb/crmask_unit_bench.sv
module crmask_unit_bench;
  localparam int XLEN = 64;
  localparam logic [4:0] XO = 5'b10110;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [31:0]     insn = '0;
  logic [31:0]     cr_in = '0;
  logic [XLEN-1:0] int_op = '0;
  logic            so_in = 1'b0;
  logic            int_we;
  logic [XLEN-1:0] int_wdata;
  logic [7:0]      cr_we;
  logic [31:0]     cr_out;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  crmask_unit u_crmask_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .cr_in(cr_in),
    .int_op(int_op), .so_in(so_in), .int_we(int_we), .int_wdata(int_wdata),
    .cr_we(cr_we), .cr_out(cr_out)
  );

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] t5, logic s_hi,
      logic [0:3] mask, logic [2:0] bb, logic s_lo, logic m, logic [4:0] xo,
      logic b26, logic [0:3] mode, logic rc);
    logic [31:0] w;
    w = {op, t5, s_hi, 4'b0, bb, s_lo, m, xo, b26, 4'b0, rc};
    for (int k = 0; k < 4; k++) begin
      w[19-k] = mask[k];
      w[4-k]  = mode[k];
    end
    return w;
  endfunction

  logic            e_iwe;
  logic [XLEN-1:0] e_idata;
  logic [7:0]      e_we;
  logic [31:0]     e_cr;
  string           e_req;

  task automatic model(logic v, logic [31:0] w, logic [31:0] cr, logic [XLEN-1:0] op, logic so);
    logic [0:3] t, s;
    logic any, all, r;
    int fld, b;
    e_iwe = 0; e_idata = '0; e_we = '0; e_cr = cr; e_req = "R1";
    if (!(v && w[31:26] == 6'd19 && w[10:6] == XO && w[5] == 1'b0)) return;
    for (int k = 0; k < 4; k++) begin
      if (w[20] && !w[12]) s[k] = (w[25:21] == 0) ? 1'b0 : op[0];
      else s[k] = cr[31 - 4*w[15:13] - k];
      t[k] = w[19-k] && (w[4-k] == s[k]);
    end
    any = t[0] | t[1] | t[2] | t[3];
    all = t[0] & t[1] & t[2] & t[3];
    r = w[11] ? any : all;
    case ({w[20], w[12]})
      2'b00: begin
        e_req = w[0] ? "R4" : "R3";
        e_iwe = 1; e_idata = {{(XLEN-1){1'b0}}, r};
        if (w[0]) begin
          e_we[1] = 1;
          e_cr[27] = 0; e_cr[26] = r; e_cr[25] = !r; e_cr[24] = so;
        end
      end
      2'b10: begin
        e_req = (w[25:21] == 0) ? "R6" : "R5";
        fld = w[15:13]; e_we[fld] = 1;
        for (int k = 0; k < 4; k++) e_cr[31 - 4*fld - k] = t[k];
      end
      2'b01: begin
        e_req = "R7";
        fld = w[25:23]; e_we[fld] = 1;
        for (int k = 0; k < 4; k++) e_cr[31 - 4*fld - k] = t[k];
      end
      default: begin
        e_req = "R8";
        fld = w[23:21]; b = w[25:24]; e_we[fld] = 1;
        e_cr[31 - 4*fld - b] = r;
      end
    endcase
  endtask

  task automatic apply(logic v, logic [31:0] w, logic [31:0] cr, logic [XLEN-1:0] op, logic so);
    in_valid = v; insn = w; cr_in = cr; int_op = op; so_in = so;
    model(v, w, cr, op, so);
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (int_we !== e_iwe || int_wdata !== e_idata || cr_we !== e_we || cr_out !== e_cr) begin
      fails++;
      $display("FAIL %s (R2 R9): got we=%b data=%h crwe=%b cr=%h exp we=%b data=%h crwe=%b cr=%h",
               e_req, int_we, int_wdata, cr_we, cr_out, e_iwe, e_idata, e_we, e_cr);
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    @(negedge clk);
    @(negedge clk);
    vectors++;
    // R10 reset state
    if (int_we !== 0 || int_wdata !== '0 || cr_we !== 0 || cr_out !== 0) begin
      fails++;
      $display("FAIL R10: got we=%b cr=%h exp zeros", int_we, cr_out);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R3 AND over all eq: field 2 = 0010 (eq set)
    apply(1, mk(19, 5'd3, 0, 4'b1111, 3'd2, 0, 0, XO, 0, 4'b0010, 0), 32'h0020_0000, '0, 0);
    // R3 OR with one matching term
    apply(1, mk(19, 5'd3, 0, 4'b0001, 3'd0, 0, 1, XO, 0, 4'b0001, 0), 32'h1000_0000, '0, 0);
    // R4 Rc with result 0 and with result 1
    apply(1, mk(19, 5'd3, 0, 4'b1000, 3'd0, 0, 1, XO, 0, 4'b1000, 1), 32'h0000_0000, '0, 1);
    apply(1, mk(19, 5'd3, 0, 4'b1000, 3'd0, 0, 1, XO, 0, 4'b1000, 1), 32'h8FFF_FFFF, '0, 0);
    // R6 constant pattern 1010 into field 5 from zero operand
    apply(1, mk(19, 5'd0, 1, 4'b1111, 3'd5, 0, 0, XO, 0, 4'b0101, 0), 32'hFFFF_FFFF, 64'h1, 0);
    // R6 set under mask and clear under mask
    apply(1, mk(19, 5'd0, 1, 4'b0110, 3'd7, 0, 0, XO, 0, 4'b0000, 0), 32'h0, '0, 0);
    apply(1, mk(19, 5'd0, 1, 4'b0110, 3'd7, 0, 0, XO, 0, 4'b1111, 0), 32'hFFFF_FFFF, '0, 0);
    // R5 integer LSB 1 from nonzero register
    apply(1, mk(19, 5'd9, 1, 4'b1111, 3'd3, 0, 0, XO, 0, 4'b1100, 0), 32'h1234_5678, 64'h3, 0);
    // R7 field 1 into field 6
    apply(1, mk(19, {3'd6, 2'b00}, 0, 4'b1011, 3'd1, 1, 0, XO, 0, 4'b1001, 0), 32'h0900_0000, '0, 0);
    // R8 single bit into field 7 bit 3 and field 0 bit 0
    apply(1, mk(19, {2'd3, 3'd7}, 1, 4'b1111, 3'd4, 1, 0, XO, 0, 4'b0000, 0), 32'h0000_0000, '0, 0);
    apply(1, mk(19, {2'd0, 3'd0}, 1, 4'b1111, 3'd4, 1, 1, XO, 0, 4'b0000, 0), 32'hFFFF_FFFF, '0, 0);
    // R1 invalid, wrong opcode, wrong XO, bit 5 set
    apply(0, mk(19, 5'd3, 0, 4'b1111, 3'd0, 0, 1, XO, 0, 4'b0000, 1), 32'hA5A5_A5A5, '0, 1);
    apply(1, mk(31, 5'd3, 1, 4'b1111, 3'd0, 0, 1, XO, 0, 4'b0000, 0), 32'h5A5A_5A5A, '0, 0);
    apply(1, mk(19, 5'd3, 1, 4'b1111, 3'd0, 1, 1, ~XO, 0, 4'b0000, 0), 32'h0F0F_0F0F, '0, 0);
    apply(1, mk(19, 5'd3, 0, 4'b1111, 3'd0, 1, 1, XO, 1, 4'b0000, 0), 32'hF0F0_F0F0, '0, 0);
    // R2 R9 random mix, mostly valid decodes
    for (int i = 0; i < 600; i++) begin
      logic [31:0] w;
      w = mk(($urandom % 8 == 0) ? 6'($urandom) : 6'd19, 5'($urandom), 1'($urandom),
             4'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
             ($urandom % 8 == 0) ? 5'($urandom) : XO, ($urandom % 8 == 0),
             4'($urandom), 1'($urandom));
      if ($urandom % 4 == 0) w[25:21] = 5'd0;
      apply(($urandom % 8) != 0, w, $urandom, {$urandom, $urandom}, 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule